// File: doc/BRIEF.md
# ADC Sample-Convert Sequencer

This block sets the timing of one successive-approximation converter channel. It makes a conversion time unit (TAD) in one of two ways: it divides the system clock by a programmable amount, or it takes one pulse of an internal converter-clock enable as each unit. Using that unit it runs a sample phase and then a fixed-length convert phase. When the conversion completes it captures the 10-bit word from a digital stand-in for the converter and presents it with a one-cycle valid pulse.

Sampling starts in one of two ways: software sets the sample bit, or the block re-enters the sample phase on its own after each conversion. Sampling ends, and conversion begins, on an event chosen by a trigger-select field. The event can be software clearing the sample bit, an edge on an external pin, a timer-compare pulse, or the end of a programmed sample time counted in TAD. A done flag records that a result is available. All logic runs on one clock.

Top module: `adc_seq_top`

## Requirements
- R1: With `clk_src_i`=0, one TAD tick occurs every `tad_div_i`+1 system cycles. The divider counter runs freely while the block is enabled and restarts from zero when `en_i` is 0.
- R2: With `clk_src_i`=1, each cycle where `int_tick_i`=1 counts as one TAD tick and `tad_div_i` has no effect.
- R3: With `trig_sel_i`=3'b111, sampling ends on the TAD tick that completes `samp_tad_i` ticks counted since the sample phase began. Conversion starts on the same clock edge.
- R4: A `samp_tad_i` value of 0 is treated as 1 TAD in 3'b111 mode.
- R5: A conversion lasts 12 TAD ticks. On the edge of the 12th tick, `rv_o` pulses for one cycle, `result_o` takes `conv_data_i` as sampled at that edge, and `done_o` is set.
- R6: With `trig_sel_i`=3'b000, or any code from 3'b011 to 3'b110, a pulse on `samp_clr_i` during sampling starts conversion at the next edge.
- R7: With `trig_sel_i`=3'b001, a rising edge on `ext_pin_i` (a cycle at 1 after a cycle at 0) during sampling starts conversion.
- R8: With `trig_sel_i`=3'b010, a `tmr_match_i` pulse during sampling starts conversion.
- R9: After a conversion completes, the block enters sampling at once if `auto_samp_i`=1. Otherwise it goes idle. From idle, a `samp_set_i` pulse starts sampling.
- R10: `done_o` stays set from completion until the next conversion starts, or until the block is disabled.
- R11: While `en_i`=0 the block sits idle, `done_o` is 0, no `rv_o` pulse occurs and `samp_set_i` is ignored.
- R12: During a conversion, triggers, `samp_set_i` and `samp_clr_i` have no effect and the conversion runs to its full length.
- R13: After reset `sh_o`, `conv_o`, `done_o`, `rv_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| clk_src_i | input | 1 | 1: TAD from internal clock enable, 0: divided system clock |
| int_tick_i | input | 1 | Internal converter clock enable |
| tad_div_i | input | 8 | TAD divider; period is value+1 cycles |
| samp_tad_i | input | 5 | Sample time in TAD (auto mode) |
| trig_sel_i | input | 3 | Conversion trigger select |
| auto_samp_i | input | 1 | Restart sampling after each conversion |
| samp_set_i | input | 1 | Software pulse: start sampling |
| samp_clr_i | input | 1 | Software pulse: end sampling (manual mode) |
| ext_pin_i | input | 1 | External trigger pin |
| tmr_match_i | input | 1 | Timer compare pulse |
| conv_data_i | input | 10 | Converter stand-in output word |
| sh_o | output | 1 | Sample/hold control, 1 while sampling |
| conv_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Conversion done flag |
| rv_o | output | 1 | Result valid pulse |
| result_o | output | 10 | Captured result |

## Verification
The assertions assume that `tad_div_i`, `clk_src_i`, `trig_sel_i`, `samp_tad_i` and `auto_samp_i` stay constant while `en_i` is 1. They also assume that the software and timer inputs are single-cycle pulses. The stimulus follows these rules by dropping `en_i` before it changes the configuration. It then compares every cycle against a behavioural model across each trigger mode, both clock sources, a zero and a maximum sample time, and pulses or pin edges that arrive during a conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMP, ST_CONV} seq_state_e;

  localparam logic [2:0] TRIG_MANUAL = 3'b000;
  localparam logic [2:0] TRIG_PIN    = 3'b001;
  localparam logic [2:0] TRIG_TMR    = 3'b010;
  localparam logic [2:0] TRIG_AUTO   = 3'b111;
endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_int_i,
  input  logic             int_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = cnt_q >= div_i;
  assign tick_o = en_i && (src_int_i ? int_tick_i : wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || src_int_i)  cnt_q <= '0;
    else if (wrap)                cnt_q <= '0;
    else                          cnt_q <= cnt_q + DIV_W'(1);
  end

  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !src_int_i && div_i != '0 && tick_o) |=> (!tick_o || src_int_i || div_i == '0));
endmodule

// File: rtl/adc_trig_mux.sv
module adc_trig_mux
  import adc_seq_pkg::*;
#(
  parameter bit PIN_RISING = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] trig_sel_i,
  input  logic       sw_clr_i,
  input  logic       ext_i,
  input  logic       tmr_i,
  input  logic       time_up_i,
  output logic       start_o
);
  logic ext_q;
  logic pin_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_i;
  end

  generate
    if (PIN_RISING) begin : g_rise
      assign pin_edge = ext_i & ~ext_q;
    end else begin : g_fall
      assign pin_edge = ~ext_i & ext_q;
    end
  endgenerate

  always_comb begin
    unique case (trig_sel_i)
      TRIG_PIN:  start_o = pin_edge;
      TRIG_TMR:  start_o = tmr_i;
      TRIG_AUTO: start_o = time_up_i;
      default:   start_o = sw_clr_i;   // manual and reserved codes
    endcase
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SAMP_W   = 5,
  parameter int DATA_W   = 10,
  parameter int CONV_TAD = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              auto_i,
  input  logic              sw_set_i,
  input  logic              tick_i,
  input  logic [SAMP_W-1:0] samp_time_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              time_up_o,
  output logic              sh_o,
  output logic              conv_o,
  output logic              done_o,
  output logic              rv_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CNT_W = $clog2(CONV_TAD);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_TAD - 1);

  seq_state_e        state_q;
  logic [SAMP_W-1:0] scnt_q;
  logic [CNT_W-1:0]  ccnt_q;
  logic [SAMP_W:0]   eff_time;

  // zero sample time is stretched to one TAD
  assign eff_time  = (samp_time_i == '0) ? (SAMP_W+1)'(1) : {1'b0, samp_time_i};
  assign time_up_o = tick_i && (({1'b0, scnt_q} + (SAMP_W+1)'(1)) >= eff_time);

  assign sh_o   = state_q == ST_SAMP;
  assign conv_o = state_q == ST_CONV;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      scnt_q   <= '0;
      ccnt_q   <= '0;
      done_o   <= 1'b0;
      rv_o     <= 1'b0;
      result_o <= '0;
    end else begin
      rv_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        scnt_q  <= '0;
        ccnt_q  <= '0;
        done_o  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (sw_set_i) begin
            state_q <= ST_SAMP;
            scnt_q  <= '0;
          end
          ST_SAMP: begin
            if (start_i) begin
              state_q <= ST_CONV;
              ccnt_q  <= '0;
              done_o  <= 1'b0;
            end else if (tick_i && scnt_q != '1) begin
              scnt_q <= scnt_q + SAMP_W'(1);
            end
          end
          ST_CONV: if (tick_i) begin
            if (ccnt_q == CONV_LAST) begin
              rv_o     <= 1'b1;
              result_o <= data_i;
              done_o   <= 1'b1;
              ccnt_q   <= '0;
              scnt_q   <= '0;
              state_q  <= auto_i ? ST_SAMP : ST_IDLE;
            end else begin
              ccnt_q <= ccnt_q + CNT_W'(1);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_rv_after_conv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rv_o |-> $past(state_q == ST_CONV));
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rv_o |-> (sh_o == $past(auto_i)));
  assert_done_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> rv_o);
  assert_off_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sh_o && !conv_o && !done_o && !rv_o));
  assert_conv_whole_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q == ST_CONV) && !conv_o && $past(en_i)) |-> rv_o);
  assert_phase_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({sh_o, conv_o}) <= 1);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int DIV_W      = 8,
  parameter int SAMP_W     = 5,
  parameter int DATA_W     = 10,
  parameter int CONV_TAD   = 12,
  parameter bit PIN_RISING = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clk_src_i,
  input  logic              int_tick_i,
  input  logic [DIV_W-1:0]  tad_div_i,
  input  logic [SAMP_W-1:0] samp_tad_i,
  input  logic [2:0]        trig_sel_i,
  input  logic              auto_samp_i,
  input  logic              samp_set_i,
  input  logic              samp_clr_i,
  input  logic              ext_pin_i,
  input  logic              tmr_match_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              sh_o,
  output logic              conv_o,
  output logic              done_o,
  output logic              rv_o,
  output logic [DATA_W-1:0] result_o
);
  logic tick, start, time_up;

  adc_tad_gen #(.DIV_W(DIV_W)) u_tad (
    .clk_i, .rst_ni, .en_i,
    .src_int_i (clk_src_i),
    .int_tick_i(int_tick_i),
    .div_i     (tad_div_i),
    .tick_o    (tick)
  );

  adc_trig_mux #(.PIN_RISING(PIN_RISING)) u_trig (
    .clk_i, .rst_ni,
    .trig_sel_i(trig_sel_i),
    .sw_clr_i  (samp_clr_i),
    .ext_i     (ext_pin_i),
    .tmr_i     (tmr_match_i),
    .time_up_i (time_up),
    .start_o   (start)
  );

  adc_seq_fsm #(.SAMP_W(SAMP_W), .DATA_W(DATA_W), .CONV_TAD(CONV_TAD)) u_fsm (
    .clk_i, .rst_ni, .en_i,
    .auto_i     (auto_samp_i),
    .sw_set_i   (samp_set_i),
    .tick_i     (tick),
    .samp_time_i(samp_tad_i),
    .start_i    (start),
    .data_i     (conv_data_i),
    .time_up_o  (time_up),
    .sh_o, .conv_o, .done_o, .rv_o, .result_o
  );
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 0, clk_src = 0, int_tick = 0, auto_samp = 0;
  logic       samp_set = 0, samp_clr = 0, ext_pin = 0, tmr_match = 0;
  logic [7:0] tad_div = 0;
  logic [4:0] samp_tad = 0;
  logic [2:0] trig_sel = 0;
  logic [9:0] conv_data = 0;
  logic       sh, conv, done, rv;
  logic [9:0] result;

  int vectors = 0, miscompares = 0;
  string cur_req = "R13";

  always #10 clk = ~clk;

  adc_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clk_src_i(clk_src),
    .int_tick_i(int_tick), .tad_div_i(tad_div), .samp_tad_i(samp_tad),
    .trig_sel_i(trig_sel), .auto_samp_i(auto_samp), .samp_set_i(samp_set),
    .samp_clr_i(samp_clr), .ext_pin_i(ext_pin), .tmr_match_i(tmr_match),
    .conv_data_i(conv_data), .sh_o(sh), .conv_o(conv), .done_o(done),
    .rv_o(rv), .result_o(result)
  );

  // behavioural reference: 0 idle, 1 sampling, 2 converting
  int m_state, m_tad, m_scnt, m_ccnt, m_done, m_rv, m_res, m_ext;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_tad = 0; m_scnt = 0; m_ccnt = 0;
      m_done = 0; m_rv = 0; m_res = 0; m_ext = 0;
    end else begin
      bit tick, edge_seen, go;
      int need, nxt_tad;
      tick      = en && (clk_src ? int_tick : (m_tad >= tad_div));
      nxt_tad   = (!en || clk_src || m_tad >= tad_div) ? 0 : m_tad + 1;
      edge_seen = ext_pin && !m_ext;
      m_ext     = ext_pin;
      m_rv      = 0;
      if (!en) begin
        m_state = 0; m_scnt = 0; m_ccnt = 0; m_done = 0;
      end else if (m_state == 0) begin
        if (samp_set) begin m_state = 1; m_scnt = 0; end
      end else if (m_state == 1) begin
        need = (samp_tad == 0) ? 1 : samp_tad;
        case (trig_sel)
          3'b001:  go = edge_seen;
          3'b010:  go = tmr_match;
          3'b111:  go = tick && (m_scnt + 1 >= need);
          default: go = samp_clr;
        endcase
        if (go) begin m_state = 2; m_ccnt = 0; m_done = 0; end
        else if (tick && m_scnt < 31) m_scnt++;
      end else if (tick) begin
        if (m_ccnt == 11) begin
          m_rv = 1; m_res = conv_data; m_done = 1;
          m_ccnt = 0; m_scnt = 0; m_state = auto_samp ? 1 : 0;
        end else m_ccnt++;
      end
      m_tad = nxt_tad;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "sh_o",     sh,     m_state == 1);
    chk(cur_req, "conv_o",   conv,   m_state == 2);
    chk(cur_req, "done_o",   done,   m_done);
    chk(cur_req, "rv_o",     rv,     m_rv);
    chk(cur_req, "result_o", result, m_res);
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      conv_data = 10'($urandom_range(0, 1023));
    end
  endtask

  task automatic pulse_set();
    step(); samp_set = 1; step(); samp_set = 0;
  endtask

  task automatic pulse_clr();
    step(); samp_clr = 1; step(); samp_clr = 0;
  endtask

  task automatic setup(bit src, int div, int st, int trig, bit aut);
    step(); en = 0; step(2);
    clk_src = src; tad_div = 8'(div); samp_tad = 5'(st);
    trig_sel = 3'(trig); auto_samp = aut; en = 1;
  endtask

  initial begin
    #(20 * 100000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R13: outputs under reset
    step(3);
    chk("R13", "sh_o", sh, 0);   chk("R13", "conv_o", conv, 0);
    chk("R13", "done_o", done, 0); chk("R13", "rv_o", rv, 0);
    chk("R13", "result_o", result, 0);
    rst_n = 1;

    // R1 R3 R5 R9: divided clock, timed sampling, auto restart
    cur_req = "R3"; setup(0, 2, 3, 3'b111, 1);
    pulse_set(); step(400);

    // R4: zero sample time
    cur_req = "R4"; setup(0, 1, 0, 3'b111, 1);
    pulse_set(); step(200);

    // R6 R12 R10: software ends sampling; pulses during conversion ignored
    cur_req = "R6"; setup(0, 0, 5, 3'b000, 0);
    pulse_set(); step(5); pulse_clr(); step(2);
    cur_req = "R12"; pulse_clr(); pulse_set(); step(20);
    cur_req = "R10"; pulse_set(); step(4); pulse_clr(); step(20);

    // R6: reserved code behaves as manual
    cur_req = "R6"; setup(0, 1, 4, 3'b101, 0);
    pulse_set(); step(6); pulse_clr(); step(40);

    // R7: pin edges, some landing during conversion
    cur_req = "R7"; setup(0, 1, 0, 3'b001, 1);
    pulse_set();
    for (int i = 0; i < 40; i++) begin
      ext_pin = ~ext_pin; step($urandom_range(1, 20));
    end
    ext_pin = 0;

    // R8: timer compare pulses
    cur_req = "R8"; setup(0, 3, 0, 3'b010, 1);
    pulse_set();
    for (int i = 0; i < 300; i++) begin
      tmr_match = ($urandom_range(0, 15) == 0); step();
    end
    tmr_match = 0;

    // R2: internal clock enable, divider ignored
    cur_req = "R2"; setup(1, 200, 2, 3'b111, 1);
    pulse_set();
    for (int i = 0; i < 400; i++) begin
      int_tick = ($urandom_range(0, 2) == 0); step();
    end
    int_tick = 0;

    // R11: disable mid-run, set pulse while off ignored
    cur_req = "R11"; setup(0, 1, 3, 3'b111, 1);
    pulse_set(); step(37);
    en = 0; step(4); pulse_set(); step(4);
    en = 1; step(6); pulse_set(); step(100);

    // R5 R1: slowest divider and longest sample time, single shot
    cur_req = "R5"; setup(0, 255, 31, 3'b111, 0);
    pulse_set(); step(11200);

    step(); en = 0; step(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule